// File: doc/BRIEF.md
# Address-Decoded Peripheral Bus Bridge

The bridge sits between a processor memory bus and an older peripheral bus that is 16 bits wide. Each request carries a 29-bit physical address. The bits are counted from the most significant end, so "bit 0" is `cpu_addr[28]` and "bit 28" is `cpu_addr[0]`. When bit 0 is clear, the request goes straight to the main-memory port. When bit 0 is set, the request is an I/O access. The address itself holds the whole peripheral command: a bus-select field, a device number, a control function and a register selector.

An I/O read becomes a data-in transaction and an I/O write becomes a data-out transaction. The bridge sends a single-cycle command pulse to the peripheral and waits for an acknowledge. A timeout closes the access with an error if no acknowledge arrives. Requests enter through a valid/ready stream. Responses to I/O accesses leave through a second valid/ready stream.

Back-pressure works as follows:
- For memory addresses, `cpu_req_ready` mirrors `mem_req_ready`.
- For I/O addresses, `cpu_req_ready` is high only while the bridge is idle.
- A response that is offered is held with unchanged contents until `cpu_rsp_ready` is high at a clock edge.

Top module: `iobr_bridge`

## Requirements
- R1: When `cpu_addr[28]`=0, `mem_req_valid` follows `cpu_req_valid`, `mem_addr`=`cpu_addr[27:0]`, `mem_write`/`mem_wdata` follow the CPU, and `cpu_req_ready` equals `mem_req_ready`. No I/O pulse results.
- R2: An accepted I/O access whose `cpu_addr[28:17]` is not 12'h800 produces no `io_req`. The cycle after acceptance it offers a response with `cpu_rsp_err`=1 and `cpu_rsp_rdata`=0.
- R3: A valid I/O access produces `io_req` high for exactly one cycle, in the cycle after acceptance, with these fields:
  - `io_dev`=`cpu_addr[16:11]`;
  - `io_func`=`cpu_addr[10:9]` (00 idle, 01 start, 10 clear, 11 pulse);
  - `io_reg`=`cpu_addr[2:1]` (00 status, 01 A, 10 B, 11 C).
- R4: `cpu_addr[8:3]` and `cpu_addr[0]` have no effect on any I/O output or response.
- R5: On a write, `io_dir_out`=1 and `io_wdata`=`cpu_wdata[15:0]`; the upper write bits are dropped. On a read, `io_dir_out`=0.
- R6: A read that is acknowledged responds with `cpu_rsp_rdata`={16'h0, `io_rdata` sampled with the ack} and `cpu_rsp_err`=0.
- R7: An `io_ack` counts only in the cycles after the pulse. The response is offered in the cycle after the counted ack. An ack while idle or during the pulse cycle is ignored.
- R8: If no ack arrives within `timeout_limit` cycles after the pulse cycle (a value of 0 acts as 1), the response carries `cpu_rsp_err`=1 and rdata 0.
- R9: While an I/O access is in flight, `cpu_req_ready` is low for I/O addresses. An offered response keeps its data and error flag until taken.
- R10: An acknowledged write responds with `cpu_rsp_err`=0 and `cpu_rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | CPU request accepted when high with valid |
| cpu_addr | input | 29 | Physical address, bit 0 = MSB |
| cpu_write | input | 1 | 1 = destination (write), 0 = source (read) |
| cpu_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | I/O response valid |
| cpu_rsp_ready | input | 1 | I/O response taken |
| cpu_rsp_rdata | output | 32 | I/O read result, zero-extended |
| cpu_rsp_err | output | 1 | Bus-select or timeout error |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_addr | output | 28 | Memory address |
| mem_write | output | 1 | Memory write flag |
| mem_wdata | output | 32 | Memory write data |
| timeout_limit | input | 8 | Cycles to wait for an ack |
| io_req | output | 1 | One-cycle command pulse |
| io_dev | output | 6 | Device code |
| io_func | output | 2 | Control function |
| io_reg | output | 2 | Register select |
| io_dir_out | output | 1 | 1 = data out, 0 = data in |
| io_wdata | output | 16 | Data-out word |
| io_ack | input | 1 | Peripheral acknowledge |
| io_rdata | input | 16 | Data-in word |

## Verification
The assertions check on every cycle:
- the single-cycle shape of the command pulse;
- the field mapping from an accepted address onto the peripheral pins;
- the suppression of the pulse after a bad bus select;
- that memory is never requested for I/O addresses;
- that a stalled response is held unchanged, and that its upper bits are zero.

Other behaviours depend on a modelled peripheral and long cycle windows, so only the bench scenarios can show them:
- the exact timeout boundary, including a limit of zero;
- that an early or stray acknowledge is ignored;
- that junk in the don't-care bits leaves the command unchanged.

// File: rtl/iobr_pkg.sv
package iobr_pkg;
  localparam int PA_W    = 29;
  localparam int DEV_W   = 6;
  localparam int SEL_W   = 12;
  localparam logic [SEL_W-1:0] LEGACY_SEL = 12'h800;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic [1:0]       func;
    logic [1:0]       rsel;
  } iobr_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } iobr_state_e;
endpackage

// File: rtl/iobr_decode.sv
module iobr_decode
  import iobr_pkg::*;
(
  input  logic [19:0] addr_hi,   // cpu_addr[28:9]
  input  logic [1:0]  addr_rsel, // cpu_addr[2:1]
  output logic        is_io,
  output logic        bus_ok,
  output iobr_cmd_t   cmd
);
  localparam int HI_W = 20;
  always_comb begin
    is_io    = addr_hi[HI_W-1];
    bus_ok   = (addr_hi[HI_W-1 -: SEL_W] == LEGACY_SEL);
    cmd.dev  = addr_hi[HI_W-SEL_W-1 -: DEV_W];
    cmd.func = addr_hi[1:0];
    cmd.rsel = addr_rsel;
  end
endmodule

// File: rtl/iobr_timer.sv
module iobr_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   next_cnt;
  logic [TMO_W:0]   lim_eff;

  always_comb begin
    next_cnt = {1'b0, cnt} + 1'b1;
    lim_eff  = (limit == '0) ? {{TMO_W{1'b0}}, 1'b1} : {1'b0, limit};
    expired  = run && (next_cnt >= lim_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (run)        cnt <= next_cnt[TMO_W-1:0];
  end
endmodule

// File: rtl/iobr_lane.sv
module iobr_lane #(
  parameter int DATA_W = 32,
  parameter int IO_W   = 16
) (
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [IO_W-1:0]   io_rdata,
  output logic [IO_W-1:0]   out_word,
  output logic [DATA_W-1:0] in_word
);
  localparam int PAD_W = DATA_W - IO_W;
  always_comb begin
    out_word = cpu_wdata[IO_W-1:0];
    in_word  = {{PAD_W{1'b0}}, io_rdata};
  end
endmodule

// File: rtl/iobr_bridge.sv
module iobr_bridge
  import iobr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IO_W   = 16,
  parameter int TMO_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req_valid,
  output logic                 cpu_req_ready,
  input  logic [PA_W-1:0]      cpu_addr,
  input  logic                 cpu_write,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic                 cpu_rsp_valid,
  input  logic                 cpu_rsp_ready,
  output logic [DATA_W-1:0]    cpu_rsp_rdata,
  output logic                 cpu_rsp_err,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [PA_W-2:0]      mem_addr,
  output logic                 mem_write,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [TMO_W-1:0]     timeout_limit,
  output logic                 io_req,
  output logic [DEV_W-1:0]     io_dev,
  output logic [1:0]           io_func,
  output logic [1:0]           io_reg,
  output logic                 io_dir_out,
  output logic [IO_W-1:0]      io_wdata,
  input  logic                 io_ack,
  input  logic [IO_W-1:0]      io_rdata
);
  iobr_state_e       state;
  iobr_cmd_t         dec_cmd, cmd_q;
  logic              dec_io, dec_ok;
  logic              wr_q, err_q;
  logic [IO_W-1:0]   wdata_q, lane_out;
  logic [DATA_W-1:0] rdata_q, lane_in;
  logic              tmo_hit, accept_io;

  iobr_decode u_dec (
    .addr_hi  (cpu_addr[PA_W-1:9]),
    .addr_rsel(cpu_addr[2:1]),
    .is_io    (dec_io),
    .bus_ok   (dec_ok),
    .cmd      (dec_cmd)
  );

  iobr_lane #(.DATA_W(DATA_W), .IO_W(IO_W)) u_lane (
    .cpu_wdata(cpu_wdata),
    .io_rdata (io_rdata),
    .out_word (lane_out),
    .in_word  (lane_in)
  );

  iobr_timer #(.TMO_W(TMO_W)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state != ST_WAIT),
    .run    ((state == ST_WAIT) && !io_ack),
    .limit  (timeout_limit),
    .expired(tmo_hit)
  );

  always_comb begin
    mem_req_valid = cpu_req_valid && !dec_io;
    mem_addr      = cpu_addr[PA_W-2:0];
    mem_write     = cpu_write;
    mem_wdata     = cpu_wdata;
    cpu_req_ready = dec_io ? (state == ST_IDLE) : mem_req_ready;
    accept_io     = cpu_req_valid && dec_io && (state == ST_IDLE);
    io_req        = (state == ST_ISSUE);
    io_dev        = cmd_q.dev;
    io_func       = cmd_q.func;
    io_reg        = cmd_q.rsel;
    io_dir_out    = wr_q;
    io_wdata      = wdata_q;
    cpu_rsp_valid = (state == ST_RESP);
    cpu_rsp_rdata = rdata_q;
    cpu_rsp_err   = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept_io) begin
          cmd_q   <= dec_cmd;
          wr_q    <= cpu_write;
          wdata_q <= lane_out;
          rdata_q <= '0;
          err_q   <= !dec_ok;
          state   <= dec_ok ? ST_ISSUE : ST_RESP;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (io_ack) begin
            rdata_q <= wr_q ? '0 : lane_in;
            err_q   <= 1'b0;
            state   <= ST_RESP;
          end else if (tmo_hit) begin
            rdata_q <= '0;
            err_q   <= 1'b1;
            state   <= ST_RESP;
          end
        end
        ST_RESP: if (cpu_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iobr_bridge_chk.sv
module iobr_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int IO_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic [28:0]       cpu_addr,
  input logic              cpu_write,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              cpu_rsp_err,
  input logic              mem_req_valid,
  input logic              io_req,
  input logic [5:0]        io_dev,
  input logic [1:0]        io_func,
  input logic [1:0]        io_reg,
  input logic              io_dir_out,
  input logic [IO_W-1:0]   io_wdata
);
  logic take_good, take_bad;
  assign take_good = cpu_req_valid && cpu_req_ready && cpu_addr[28] && (cpu_addr[27:17] == '0);
  assign take_bad  = cpu_req_valid && cpu_req_ready && cpu_addr[28] && (cpu_addr[27:17] != '0);

  AST_NO_MEM_FOR_IO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[28] |-> !mem_req_valid); // R1
  AST_BAD_SEL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> !io_req && cpu_rsp_valid && cpu_rsp_err && (cpu_rsp_rdata == '0)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |=> !io_req); // R3
  AST_CMD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    take_good |=> io_req && io_dev == $past(cpu_addr[16:11]) && io_func == $past(cpu_addr[10:9])
                  && io_reg == $past(cpu_addr[2:1])); // R3
  AST_OUT_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    take_good |=> io_dir_out == $past(cpu_write) && io_wdata == $past(cpu_wdata[IO_W-1:0])); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> cpu_rsp_rdata[DATA_W-1:IO_W] == '0); // R6
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && cpu_addr[28]) |-> !cpu_req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> cpu_rsp_valid && $stable(cpu_rsp_rdata) && $stable(cpu_rsp_err)); // R9
endmodule

bind iobr_bridge iobr_bridge_chk #(.DATA_W(DATA_W), .IO_W(IO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_addr(cpu_addr), .cpu_write(cpu_write), .cpu_wdata(cpu_wdata),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
  .cpu_rsp_err(cpu_rsp_err), .mem_req_valid(mem_req_valid), .io_req(io_req), .io_dev(io_dev),
  .io_func(io_func), .io_reg(io_reg), .io_dir_out(io_dir_out), .io_wdata(io_wdata)
);

// File: tb/iobr_bridge_tb.sv
module iobr_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_ready;
  logic [28:0] cpu_addr = '0;
  logic        cpu_write = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rsp_valid, cpu_rsp_ready = 1'b1;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_err;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [27:0] mem_addr;
  logic        mem_write;
  logic [31:0] mem_wdata;
  logic [7:0]  timeout_limit = 8'd6;
  logic        io_req;
  logic [5:0]  io_dev;
  logic [1:0]  io_func, io_reg;
  logic        io_dir_out;
  logic [15:0] io_wdata;
  logic        io_ack = 1'b0;
  logic [15:0] io_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iobr_bridge dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // field extraction with bit 0 = MSB numbering
  function automatic int fld(input logic [28:0] a, input int first, input int last);
    int v = 0;
    for (int k = first; k <= last; k++) v = (v << 1) | int'(a[28 - k]);
    return v;
  endfunction

  function automatic logic [28:0] mk(input int sel, input int dev, input int fn,
                                     input int rs, input int junk, input int b28);
    logic [28:0] a = '0;
    for (int k = 0; k < 12; k++) a[28-k] = sel[11-k];
    for (int k = 0; k < 6; k++)  a[16-k] = dev[5-k];
    for (int k = 0; k < 2; k++)  a[10-k] = fn[1-k];
    for (int k = 0; k < 6; k++)  a[8-k]  = junk[5-k];
    for (int k = 0; k < 2; k++)  a[2-k]  = rs[1-k];
    a[0] = b28[0];
    return a;
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_phase;  // 0 idle, 1 pulse, 2 waiting, 3 responding
  int m_wait;
  int m_dev, m_fn, m_rs, m_wr, m_wd;
  longint m_rd;
  int m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase <= 0; m_wait <= 0; m_err <= 0; m_rd <= 0;
      m_dev <= 0; m_fn <= 0; m_rs <= 0; m_wr <= 0; m_wd <= 0;
    end else begin
      case (m_phase)
        0: if (cpu_req_valid && cpu_addr[28]) begin
          m_dev <= fld(cpu_addr, 12, 17);
          m_fn  <= fld(cpu_addr, 18, 19);
          m_rs  <= fld(cpu_addr, 26, 27);
          m_wr  <= int'(cpu_write);
          m_wd  <= int'(cpu_wdata % 65536);
          m_rd  <= 0;
          if (fld(cpu_addr, 0, 11) != 2048) begin m_err <= 1; m_phase <= 3; end
          else begin m_err <= 0; m_phase <= 1; end
        end
        1: begin m_phase <= 2; m_wait <= 0; end
        2: begin
          if (io_ack) begin
            m_err <= 0; m_rd <= m_wr ? 0 : longint'(io_rdata); m_phase <= 3;
          end else if (m_wait + 1 >= ((timeout_limit == 0) ? 1 : int'(timeout_limit))) begin
            m_err <= 1; m_rd <= 0; m_phase <= 3;
          end else m_wait <= m_wait + 1;
        end
        default: if (cpu_rsp_ready) m_phase <= 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(io_req == (m_phase == 1), "R3 pulse timing", io_req, m_phase == 1);
    chk(cpu_rsp_valid == (m_phase == 3), "R7 response timing", cpu_rsp_valid, m_phase == 3);
    if (io_req) begin
      chk(io_dev == m_dev, "R3 device", io_dev, m_dev);
      chk(io_func == m_fn, "R3 function", io_func, m_fn);
      chk(io_reg == m_rs, "R3 register", io_reg, m_rs);
      chk(io_dir_out == m_wr, "R5 direction", io_dir_out, m_wr);
      chk(io_wdata == m_wd, "R5 out data", io_wdata, m_wd);
    end
    if (cpu_rsp_valid) begin
      chk(cpu_rsp_rdata == m_rd, "R6 response data", cpu_rsp_rdata, m_rd);
      chk(cpu_rsp_err == m_err, "R8 response error", cpu_rsp_err, m_err);
    end
    if (cpu_addr[28]) begin
      chk(!mem_req_valid, "R1 no memory for I/O", mem_req_valid, 0);
      chk(cpu_req_ready == (m_phase == 0), "R9 I/O ready", cpu_req_ready, m_phase == 0);
    end else begin
      chk(mem_req_valid == cpu_req_valid, "R1 mem valid", mem_req_valid, cpu_req_valid);
      chk(cpu_req_ready == mem_req_ready, "R1 mem ready", cpu_req_ready, mem_req_ready);
      if (cpu_req_valid) begin
        chk(mem_addr == cpu_addr[27:0], "R1 mem addr", mem_addr, cpu_addr[27:0]);
        chk(mem_wdata == cpu_wdata && mem_write == cpu_write, "R1 mem data", mem_wdata, cpu_wdata);
      end
    end
  end

  // ---------------- peripheral model ----------------
  int per_delay = 0;   // -1: never acknowledge
  bit per_early = 0;
  bit per_pend = 0;
  int per_cnt = 0;
  always @(negedge clk) if (io_req) begin
    per_pend = (per_delay >= 0);
    per_cnt  = per_delay;
    if (per_early) io_ack = 1'b1;
  end
  always @(posedge clk) begin
    #2;
    if (per_pend) begin
      if (per_cnt == 0) begin io_ack = 1'b1; per_pend = 0; end
      else begin per_cnt--; io_ack = 1'b0; end
    end else io_ack = 1'b0;
  end

  // ---------------- stimulus ----------------
  longint got_rd;
  int got_err, got_dev, got_fn, got_rs, got_wd;
  always @(negedge clk) if (io_req) begin
    got_dev = io_dev; got_fn = io_func; got_rs = io_reg; got_wd = io_wdata;
  end

  task automatic io_txn(input logic [28:0] a, input bit wr, input logic [31:0] wd,
                        input int delay, input int hold);
    per_delay = delay;
    @(posedge clk); #2;
    cpu_addr = a; cpu_write = wr; cpu_wdata = wd; cpu_req_valid = 1'b1;
    if (hold > 0) cpu_rsp_ready = 1'b0;
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk); #2;
    cpu_req_valid = 1'b0;
    @(negedge clk);
    while (!cpu_rsp_valid) @(negedge clk);
    got_rd = cpu_rsp_rdata; got_err = cpu_rsp_err;
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      chk(cpu_rsp_valid && cpu_rsp_rdata == got_rd && cpu_rsp_err == got_err,
          "R9 held response", cpu_rsp_rdata, got_rd);
      @(posedge clk); #2; cpu_rsp_ready = 1'b1;
    end
    @(negedge clk);
    while (cpu_rsp_valid) @(negedge clk);
  endtask

  task automatic mem_txn(input logic [27:0] a, input bit wr, input logic [31:0] wd, input int stall);
    @(posedge clk); #2;
    cpu_addr = {1'b0, a}; cpu_write = wr; cpu_wdata = wd; cpu_req_valid = 1'b1;
    mem_req_ready = (stall == 0);
    repeat (stall) begin @(posedge clk); #2; end
    mem_req_ready = 1'b1;
    @(negedge clk);
    chk(mem_req_valid && cpu_req_ready && mem_addr == a, "R1 memory pass", mem_addr, a);
    @(posedge clk); #2; cpu_req_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!io_req && !cpu_rsp_valid, "R3 reset state", {io_req, cpu_rsp_valid}, 0);

    // R1 memory path with and without stall
    mem_txn(28'h0ABCDEF, 1'b1, 32'hDEAD_BEEF, 0);
    mem_txn(28'hFFFFFFF, 1'b0, 32'h1234_5678, 3);

    // R3 R6 reads over several device/function/register patterns
    io_rdata = 16'hA55A;
    io_txn(mk(12'h800, 5, 1, 1, 0, 0), 1'b0, 32'h0, 0, 0);
    chk(got_err == 0 && got_rd == 64'hA55A, "R6 read data", got_rd, 64'hA55A);
    chk(got_dev == 5 && got_fn == 1 && got_rs == 1, "R3 decode dev5 start A", got_dev, 5);
    io_rdata = 16'hFFFF;
    io_txn(mk(12'h800, 63, 3, 3, 0, 0), 1'b0, 32'h0, 2, 0);
    chk(got_rd == 64'hFFFF && got_dev == 63 && got_fn == 3 && got_rs == 3, "R6 read dev63 C", got_rd, 64'hFFFF);
    io_txn(mk(12'h800, 0, 2, 2, 0, 0), 1'b0, 32'h0, 1, 0);
    chk(got_dev == 0 && got_fn == 2 && got_rs == 2, "R3 decode dev0 clear B", got_fn, 2);

    // R5 R10 write drops upper bits
    io_txn(mk(12'h800, 17, 0, 0, 0, 0), 1'b1, 32'hCAFE_1357, 0, 0);
    chk(got_wd == 16'h1357, "R5 low half sent", got_wd, 16'h1357);
    chk(got_err == 0 && got_rd == 0, "R10 write response", got_rd, 0);

    // R4 junk in ignored bits
    io_rdata = 16'h0C0C;
    io_txn(mk(12'h800, 42, 1, 2, 6'h3F, 1), 1'b0, 32'h0, 0, 0);
    chk(got_dev == 42 && got_fn == 1 && got_rs == 2 && got_rd == 64'h0C0C, "R4 ignored bits", got_dev, 42);

    // R2 bad bus select
    io_txn(mk(12'h801, 3, 1, 1, 0, 0), 1'b0, 32'h0, 0, 0);
    chk(got_err == 1 && got_rd == 0, "R2 bad select 801", got_err, 1);
    io_txn(mk(12'hC00, 3, 1, 1, 0, 0), 1'b1, 32'h5, 0, 0);
    chk(got_err == 1, "R2 bad select C00", got_err, 1);

    // R8 timeout boundary with limit 4: delay 3 last accepted, delay 4 times out
    timeout_limit = 8'd4;
    io_rdata = 16'h1111;
    io_txn(mk(12'h800, 9, 1, 1, 0, 0), 1'b0, 32'h0, 3, 0);
    chk(got_err == 0 && got_rd == 64'h1111, "R8 ack at last cycle", got_err, 0);
    io_txn(mk(12'h800, 9, 1, 1, 0, 0), 1'b0, 32'h0, 4, 0);
    chk(got_err == 1 && got_rd == 0, "R8 timeout", got_err, 1);
    timeout_limit = 8'd0;
    io_txn(mk(12'h800, 9, 1, 1, 0, 0), 1'b0, 32'h0, 1, 0);
    chk(got_err == 1, "R8 zero limit acts as one", got_err, 1);
    timeout_limit = 8'd6;

    // R7 ack during pulse cycle and while idle are ignored
    per_early = 1;
    io_txn(mk(12'h800, 4, 0, 0, 0, 0), 1'b0, 32'h0, -1, 0);
    per_early = 0;
    chk(got_err == 1, "R7 early ack ignored", got_err, 1);
    @(posedge clk); #2 io_ack = 1'b1;
    @(negedge clk);
    chk(!cpu_rsp_valid && !io_req, "R7 idle ack ignored", cpu_rsp_valid, 0);

    // R9 response back-pressure
    io_rdata = 16'h7E7E;
    io_txn(mk(12'h800, 12, 3, 1, 0, 0), 1'b0, 32'h0, 0, 4);
    chk(got_rd == 64'h7E7E, "R9 stalled read", got_rd, 64'h7E7E);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule